// File: doc/BRIEF.md
# Dual-Port Synchronous Byte-Lane RAM

This block is a two-port synchronous static memory with 18-bit words. Each word is split into two 9-bit lanes: the upper lane is bits 17 to 9 and the lower lane is bits 8 to 0. The two ports, left and right, are identical and independent. Each has its own clock, registered address, registered control and registered write data. Both ports can reach every location, including the same location in the same cycle. The default depth is 4K words (`ADDR_W = 12`). Setting `ADDR_W = 13` gives 8K words.

A port is selected when its active-low enable is low and its active-high enable is high on a rising clock edge. When selected, the read/write line decides between a read (high) and a write (low). Two active-low lane selects limit the access to the chosen lanes. The read result leaves on a plain output bus, together with a per-lane output-enable vector that stands in for a tri-state driver.

A static mode input on each port picks flow-through or pipelined read output. An active-low output enable is applied combinationally as the last gate on the lane enables. The synchronous active-high reset clears the control pipelines of both ports but not the stored data. Reset must be held across at least two edges of each port clock.

Top module: `dual_port_lane_ram`

## Requirements
- R1: A selected write (read/write low) stores `wdata` only into lanes whose lane select is low. Lane 1 is bits 17:9 and lane 0 is bits 8:0, and bit i of the lane-select bus belongs to lane i. Unselected lanes keep their contents.
- R2: A port cycle is active only if `ce_n` is 0 and `ce` is 1 at the clock edge. In any other cycle nothing is written, and the read lane enables for that cycle stay 0.
- R3: On the edge where the port is selected, `rw` high samples a read and `rw` low samples a write. A write never raises the read lane enables.
- R4: In flow-through mode (`pipe` = 0), a read sampled at edge k drives `rdata` and raises the lane enables after edge k+1, for one cycle.
- R5: In pipelined mode (`pipe` = 1), the same read appears one cycle later, after edge k+2. The enable decode passes through one more register stage, so a deselect also takes one more cycle to reach the output.
- R6: The lane selects that gate the read lane enables pass through a single register stage in both modes. In pipelined mode, the enables after edge k+2 use the lane selects sampled at edge k+1.
- R7: While `oe_n` is 1, both read lane enables are 0 at once, without waiting for a clock edge.
- R8: Data written by one port can be read by the other port from the following cycle on.
- R9: A read on one port of a lane that the other port writes in the same cycle returns the contents from before that write.
- R10: If both ports write the same lane of the same address in the same cycle, the left port's data is kept.
- R11: After reset, both ports' read lane enables are 0 until a new read comes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset for both port pipelines |
| lt_clk | input | 1 | Left port clock |
| lt_ce_n | input | 1 | Left active-low chip enable |
| lt_ce | input | 1 | Left active-high chip enable |
| lt_rw | input | 1 | Left read (1) / write (0) |
| lt_lane_n | input | 2 | Left active-low lane selects, bit 1 = bits 17:9 |
| lt_addr | input | ADDR_W | Left word address |
| lt_wdata | input | 18 | Left write data |
| lt_oe_n | input | 1 | Left asynchronous active-low output enable |
| lt_pipe | input | 1 | Left output mode, 1 = pipelined |
| lt_rdata | output | 18 | Left read data |
| lt_rdata_oe | output | 2 | Left per-lane read drive enables |
| rt_clk | input | 1 | Right port clock |
| rt_ce_n | input | 1 | Right active-low chip enable |
| rt_ce | input | 1 | Right active-high chip enable |
| rt_rw | input | 1 | Right read (1) / write (0) |
| rt_lane_n | input | 2 | Right active-low lane selects, bit 1 = bits 17:9 |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | 18 | Right write data |
| rt_oe_n | input | 1 | Right asynchronous active-low output enable |
| rt_pipe | input | 1 | Right output mode, 1 = pipelined |
| rt_rdata | output | 18 | Right read data |
| rt_rdata_oe | output | 2 | Right per-lane read drive enables |

## Verification
Both output modes are exercised with full-word, upper-only and lower-only writes, and the reads of those words show whether lane masking and read latency are right. Deselects through each enable polarity separately reveal an enable decode that ignores one of the two pins. In pipelined mode, lane selects are changed during the cycle after a read, which separates a single-stage lane path from a double-stage one. The other cases are cross-port traffic, a read against a same-cycle write from the other port, a same-lane write collision, and an output-enable toggle in mid-cycle; these expose ordering, priority and combinational-gating faults.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [LANES-1:0]  lane_vec_t;
    typedef logic [WORD_W-1:0] word_t;

    // registered command of one port
    typedef struct packed {
        logic      sel;
        logic      rd;
        lane_vec_t lane_n;
        word_t     data;
    } port_cmd_t;

    localparam port_cmd_t CMD_IDLE = '{sel: 1'b0, rd: 1'b0, lane_n: '1, data: '0};

    // per lane: take b where use_b is set, else a
    function automatic word_t pick_lanes(word_t a, word_t b, lane_vec_t use_b);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = use_b[i] ? b[i*LANE_W +: LANE_W] : a[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/dlr_port_ctrl.sv
module dlr_port_ctrl
    import dlr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              rw,
    input  lane_vec_t         lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  logic              oe_n,
    input  logic              pipe,
    input  word_t             rd_word,
    output logic [ADDR_W-1:0] acc_addr,
    output word_t             wr_data,
    output lane_vec_t         wr_lane,
    output word_t             rdata,
    output lane_vec_t         rdata_oe
);

    port_cmd_t         cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_en1, rd_en2;
    lane_vec_t         lane_d1;
    word_t             rd_q1, rd_q2;
    logic              en_sel;

    // stage 0: input registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_IDLE;
            addr_q <= '0;
        end else begin
            cmd_q.sel    <= ~ce_n & ce;
            cmd_q.rd     <= rw;
            cmd_q.lane_n <= lane_n;
            cmd_q.data   <= wdata;
            addr_q       <= addr;
        end
    end

    // enable pipeline: chip-enable decode has two stages, lane selects one
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en1  <= 1'b0;
            rd_en2  <= 1'b0;
            lane_d1 <= '1;
        end else begin
            rd_en1  <= cmd_q.sel & cmd_q.rd;
            rd_en2  <= rd_en1;
            lane_d1 <= cmd_q.lane_n;
        end
    end

    // read data stages
    always_ff @(posedge clk) begin
        rd_q1 <= rd_word;
        rd_q2 <= rd_q1;
    end

    assign acc_addr = addr_q;
    assign wr_data  = cmd_q.data;
    assign wr_lane  = {LANES{cmd_q.sel & ~cmd_q.rd}} & ~cmd_q.lane_n;

    assign en_sel   = pipe ? rd_en2 : rd_en1;
    assign rdata    = pipe ? rd_q2 : rd_q1;
    assign rdata_oe = {LANES{en_sel & ~oe_n}} & ~lane_d1;

endmodule

// File: rtl/dlr_bank.sv
module dlr_bank
    import dlr_pkg::*;
#(
    parameter int   ADDR_W   = 12,
    parameter logic TAG_FLIP = 1'b0
) (
    input  logic              clk,
    input  lane_vec_t         wr_lane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  lane_vec_t         peer_tag,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] probe_addr,
    output word_t             rd_data_a,
    output lane_vec_t         rd_tag_a,
    output word_t             rd_data_b,
    output lane_vec_t         rd_tag_b,
    output lane_vec_t         probe_tag
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t     store [DEPTH];
    lane_vec_t tag   [DEPTH];

    // a write marks this bank as the newest copy of the lane
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_lane[i]) begin
                store[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
                tag[wr_addr][i]                    <= peer_tag[i] ^ TAG_FLIP;
            end
        end
    end

    assign rd_data_a = store[rd_addr_a];
    assign rd_tag_a  = tag[rd_addr_a];
    assign rd_data_b = store[rd_addr_b];
    assign rd_tag_b  = tag[rd_addr_b];
    assign probe_tag = tag[probe_addr];

endmodule

// File: rtl/dual_port_lane_ram.sv
module dual_port_lane_ram
    import dlr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              rst,
    input  logic              lt_clk,
    input  logic              lt_ce_n,
    input  logic              lt_ce,
    input  logic              lt_rw,
    input  logic [1:0]        lt_lane_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [17:0]       lt_wdata,
    input  logic              lt_oe_n,
    input  logic              lt_pipe,
    output logic [17:0]       lt_rdata,
    output logic [1:0]        lt_rdata_oe,
    input  logic              rt_clk,
    input  logic              rt_ce_n,
    input  logic              rt_ce,
    input  logic              rt_rw,
    input  logic [1:0]        rt_lane_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [17:0]       rt_wdata,
    input  logic              rt_oe_n,
    input  logic              rt_pipe,
    output logic [17:0]       rt_rdata,
    output logic [1:0]        rt_rdata_oe
);

    logic [ADDR_W-1:0] l_acc, r_acc;
    word_t             l_wd, r_wd, l_word, r_word;
    lane_vec_t         l_wl, r_wl, r_wl_eff;
    word_t             bl_da, bl_db, br_da, br_db;
    lane_vec_t         bl_ta, bl_tb, br_ta, br_tb, bl_probe, br_probe;

    dlr_port_ctrl #(.ADDR_W(ADDR_W)) u_lt (
        .clk(lt_clk), .rst(rst), .ce_n(lt_ce_n), .ce(lt_ce), .rw(lt_rw),
        .lane_n(lt_lane_n), .addr(lt_addr), .wdata(lt_wdata), .oe_n(lt_oe_n),
        .pipe(lt_pipe), .rd_word(l_word), .acc_addr(l_acc), .wr_data(l_wd),
        .wr_lane(l_wl), .rdata(lt_rdata), .rdata_oe(lt_rdata_oe)
    );

    dlr_port_ctrl #(.ADDR_W(ADDR_W)) u_rt (
        .clk(rt_clk), .rst(rst), .ce_n(rt_ce_n), .ce(rt_ce), .rw(rt_rw),
        .lane_n(rt_lane_n), .addr(rt_addr), .wdata(rt_wdata), .oe_n(rt_oe_n),
        .pipe(rt_pipe), .rd_word(r_word), .acc_addr(r_acc), .wr_data(r_wd),
        .wr_lane(r_wl), .rdata(rt_rdata), .rdata_oe(rt_rdata_oe)
    );

    // same-lane same-address collision: the left write is kept
    always_comb begin
        r_wl_eff = r_wl;
        if (l_acc == r_acc) r_wl_eff = r_wl & ~l_wl;
    end

    // left bank: equal tags mean left holds the newest lane
    dlr_bank #(.ADDR_W(ADDR_W), .TAG_FLIP(1'b0)) u_bank_lt (
        .clk(lt_clk), .wr_lane(l_wl), .wr_addr(l_acc), .wr_data(l_wd),
        .peer_tag(br_probe), .rd_addr_a(l_acc), .rd_addr_b(r_acc),
        .probe_addr(r_acc), .rd_data_a(bl_da), .rd_tag_a(bl_ta),
        .rd_data_b(bl_db), .rd_tag_b(bl_tb), .probe_tag(bl_probe)
    );

    // right bank: differing tags mean right holds the newest lane
    dlr_bank #(.ADDR_W(ADDR_W), .TAG_FLIP(1'b1)) u_bank_rt (
        .clk(rt_clk), .wr_lane(r_wl_eff), .wr_addr(r_acc), .wr_data(r_wd),
        .peer_tag(bl_probe), .rd_addr_a(l_acc), .rd_addr_b(r_acc),
        .probe_addr(l_acc), .rd_data_a(br_da), .rd_tag_a(br_ta),
        .rd_data_b(br_db), .rd_tag_b(br_tb), .probe_tag(br_probe)
    );

    assign l_word = pick_lanes(bl_da, br_da, bl_ta ^ br_ta);
    assign r_word = pick_lanes(bl_db, br_db, bl_tb ^ br_tb);

endmodule

// File: rtl/dlr_check.sv
module dlr_check #(
    parameter int ADDR_W = 12
) (
    input logic              rst,
    input logic              lt_clk,
    input logic              lt_ce_n,
    input logic              lt_ce,
    input logic              lt_rw,
    input logic [1:0]        lt_lane_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic [17:0]       lt_wdata,
    input logic              lt_oe_n,
    input logic              lt_pipe,
    input logic [17:0]       lt_rdata,
    input logic [1:0]        lt_rdata_oe,
    input logic              rt_clk,
    input logic              rt_ce_n,
    input logic              rt_ce,
    input logic              rt_rw,
    input logic [1:0]        rt_lane_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic [17:0]       rt_wdata,
    input logic              rt_oe_n,
    input logic              rt_pipe,
    input logic [17:0]       rt_rdata,
    input logic [1:0]        rt_rdata_oe
);

    assert_oe_gate_R7_lt: assert property (@(posedge lt_clk) disable iff (rst)
        lt_oe_n |-> lt_rdata_oe == 2'b00);
    assert_oe_gate_R7_rt: assert property (@(posedge rt_clk) disable iff (rst)
        rt_oe_n |-> rt_rdata_oe == 2'b00);

    assert_flow_lat_R4_lt: assert property (@(posedge lt_clk) disable iff (rst)
        (!lt_pipe && lt_rdata_oe != 2'b00) |-> $past(!lt_ce_n && lt_ce && lt_rw, 2));
    assert_flow_lat_R4_rt: assert property (@(posedge rt_clk) disable iff (rst)
        (!rt_pipe && rt_rdata_oe != 2'b00) |-> $past(!rt_ce_n && rt_ce && rt_rw, 2));

    assert_pipe_lat_R5_lt: assert property (@(posedge lt_clk) disable iff (rst)
        (lt_pipe && lt_rdata_oe != 2'b00) |-> $past(!lt_ce_n && lt_ce && lt_rw, 3));
    assert_pipe_lat_R5_rt: assert property (@(posedge rt_clk) disable iff (rst)
        (rt_pipe && rt_rdata_oe != 2'b00) |-> $past(!rt_ce_n && rt_ce && rt_rw, 3));

    assert_lane_stage_R6_lt_up: assert property (@(posedge lt_clk) disable iff (rst)
        lt_rdata_oe[1] |-> $past(!lt_lane_n[1], 2));
    assert_lane_stage_R6_lt_lo: assert property (@(posedge lt_clk) disable iff (rst)
        lt_rdata_oe[0] |-> $past(!lt_lane_n[0], 2));
    assert_lane_stage_R6_rt_up: assert property (@(posedge rt_clk) disable iff (rst)
        rt_rdata_oe[1] |-> $past(!rt_lane_n[1], 2));
    assert_lane_stage_R6_rt_lo: assert property (@(posedge rt_clk) disable iff (rst)
        rt_rdata_oe[0] |-> $past(!rt_lane_n[0], 2));

endmodule

bind dual_port_lane_ram dlr_check #(.ADDR_W(ADDR_W)) u_dlr_check (.*);

// File: tb/dual_port_lane_ram_bench.sv
module dual_port_lane_ram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DEPTH      = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              lt_ce_n = 1'b1, lt_ce = 1'b1, lt_rw = 1'b1, lt_oe_n = 1'b0, lt_pipe = 1'b0;
    logic [1:0]        lt_lane_n = 2'b00;
    logic [ADDR_W-1:0] lt_addr = '0;
    logic [17:0]       lt_wdata = '0;
    logic [17:0]       lt_rdata;
    logic [1:0]        lt_rdata_oe;
    logic              rt_ce_n = 1'b1, rt_ce = 1'b1, rt_rw = 1'b1, rt_oe_n = 1'b0, rt_pipe = 1'b0;
    logic [1:0]        rt_lane_n = 2'b00;
    logic [ADDR_W-1:0] rt_addr = '0;
    logic [17:0]       rt_wdata = '0;
    logic [17:0]       rt_rdata;
    logic [1:0]        rt_rdata_oe;

    dual_port_lane_ram #(.ADDR_W(ADDR_W)) u_dual_port_lane_ram (
        .rst(rst),
        .lt_clk(clk), .lt_ce_n(lt_ce_n), .lt_ce(lt_ce), .lt_rw(lt_rw), .lt_lane_n(lt_lane_n),
        .lt_addr(lt_addr), .lt_wdata(lt_wdata), .lt_oe_n(lt_oe_n), .lt_pipe(lt_pipe),
        .lt_rdata(lt_rdata), .lt_rdata_oe(lt_rdata_oe),
        .rt_clk(clk), .rt_ce_n(rt_ce_n), .rt_ce(rt_ce), .rt_rw(rt_rw), .rt_lane_n(rt_lane_n),
        .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_oe_n(rt_oe_n), .rt_pipe(rt_pipe),
        .rt_rdata(rt_rdata), .rt_rdata_oe(rt_rdata_oe)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R11";

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit       sel;
        bit       rd;
        bit [1:0] ln;
        int       addr;
        bit [17:0] d;
    } ref_cmd_t;

    logic [17:0] ref_mem [DEPTH];
    ref_cmd_t    cA [2], cB [2], cC [2];
    logic [17:0] rd_now [2], rd_prev [2];

    function automatic ref_cmd_t idle_cmd();
        ref_cmd_t c;
        c.sel = 0; c.rd = 0; c.ln = 2'b11; c.addr = 0; c.d = '0;
        return c;
    endfunction

    always @(posedge clk) begin
        ref_cmd_t    s [2];
        logic [17:0] rnew [2];
        s[0].sel = !lt_ce_n && lt_ce; s[0].rd = lt_rw; s[0].ln = lt_lane_n;
        s[0].addr = int'(lt_addr); s[0].d = lt_wdata;
        s[1].sel = !rt_ce_n && rt_ce; s[1].rd = rt_rw; s[1].ln = rt_lane_n;
        s[1].addr = int'(rt_addr); s[1].d = rt_wdata;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                cA[p] = idle_cmd(); cB[p] = idle_cmd(); cC[p] = idle_cmd();
            end
        end else begin
            // reads see the contents from before this edge's writes
            for (int p = 0; p < 2; p++) rnew[p] = ref_mem[cA[p].addr];
            // right first, so a same-lane left write overrides it
            for (int p = 1; p >= 0; p--) begin
                if (cA[p].sel && !cA[p].rd) begin
                    if (!cA[p].ln[1]) ref_mem[cA[p].addr][17:9] = cA[p].d[17:9];
                    if (!cA[p].ln[0]) ref_mem[cA[p].addr][8:0]  = cA[p].d[8:0];
                end
            end
            for (int p = 0; p < 2; p++) begin
                rd_prev[p] = rd_now[p];
                rd_now[p]  = rnew[p];
                cC[p] = cB[p];
                cB[p] = cA[p];
                cA[p] = s[p];
            end
        end
    end

    task automatic check_port(input int p, input logic pipe, input logic oe_n,
                              input logic [17:0] act_d, input logic [1:0] act_oe);
        bit          en;
        logic [1:0]  exp_oe;
        logic [17:0] exp_d;
        en     = pipe ? (cC[p].sel && cC[p].rd) : (cB[p].sel && cB[p].rd);
        exp_oe = (en && !oe_n) ? ~cB[p].ln : 2'b00;
        exp_d  = pipe ? rd_prev[p] : rd_now[p];
        for (int l = 0; l < 2; l++) begin
            n_checks++;
            if (act_oe[l] !== exp_oe[l]) begin
                n_fail++;
                $display("FAIL %s port%0d lane%0d enable: actual %b expected %b at %0t",
                         cur_req, p, l, act_oe[l], exp_oe[l], $time);
            end
            if (exp_oe[l]) begin
                n_checks++;
                if (act_d[l*9 +: 9] !== exp_d[l*9 +: 9]) begin
                    n_fail++;
                    $display("FAIL %s port%0d lane%0d data: actual %h expected %h at %0t",
                             cur_req, p, l, act_d[l*9 +: 9], exp_d[l*9 +: 9], $time);
                end
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!rst) begin
            check_port(0, lt_pipe, lt_oe_n, lt_rdata, lt_rdata_oe);
            check_port(1, rt_pipe, rt_oe_n, rt_rdata, rt_rdata_oe);
        end
    endtask

    task automatic drv_l(input bit ce_n, input bit ce, input bit rw, input bit [1:0] ln,
                         input int a, input bit [17:0] d);
        lt_ce_n = ce_n; lt_ce = ce; lt_rw = rw; lt_lane_n = ln;
        lt_addr = a[ADDR_W-1:0]; lt_wdata = d;
    endtask

    task automatic drv_r(input bit ce_n, input bit ce, input bit rw, input bit [1:0] ln,
                         input int a, input bit [17:0] d);
        rt_ce_n = ce_n; rt_ce = ce; rt_rw = rw; rt_lane_n = ln;
        rt_addr = a[ADDR_W-1:0]; rt_wdata = d;
    endtask

    task automatic idle_both();
        drv_l(1, 1, 1, 2'b00, 0, '0);
        drv_r(1, 1, 1, 2'b00, 0, '0);
    endtask

    task automatic drain(input int n);
        idle_both();
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b0;
    endtask

    bit done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle_both();
        do_reset();
        // R11: enables low right after reset
        cur_req = "R11";
        n_checks++;
        if (lt_rdata_oe !== 2'b00 || rt_rdata_oe !== 2'b00) begin
            n_fail++;
            $display("FAIL R11 reset enables: actual %b/%b expected 00/00", lt_rdata_oe, rt_rdata_oe);
        end
        step();

        // ---- flow-through mode ----
        // R1 R3: full, upper-only and lower-only writes, then reads
        cur_req = "R1";
        drv_l(0, 1, 0, 2'b00, 5, 18'h2A5A5); step();
        drv_l(0, 1, 0, 2'b00, 6, 18'h3FFFF); step();
        drv_l(0, 1, 0, 2'b01, 6, 18'h00000); step();
        drv_l(0, 1, 0, 2'b10, 5, 18'h1FF00); step();
        cur_req = "R3";
        drv_l(0, 1, 1, 2'b00, 5, 18'h11111); step();
        drv_l(0, 1, 1, 2'b00, 6, 18'h22222); step();
        cur_req = "R4";
        drv_l(0, 1, 1, 2'b10, 6, '0); step();
        drv_l(0, 1, 1, 2'b01, 5, '0); step();
        drain(3);

        // R2: each enable polarity deselects on its own
        cur_req = "R2";
        drv_l(1, 1, 0, 2'b00, 5, 18'h0BEEF); step();
        drv_l(0, 0, 0, 2'b00, 5, 18'h0CAFE); step();
        drv_l(1, 1, 1, 2'b00, 5, '0); step();
        drv_l(0, 0, 1, 2'b00, 5, '0); step();
        drv_l(0, 1, 1, 2'b00, 5, '0); step();
        drain(3);

        // R8: cross-port visibility both ways
        cur_req = "R8";
        drv_l(0, 1, 0, 2'b00, 9, 18'h13579); drv_r(0, 1, 0, 2'b00, 10, 18'h2468A); step();
        drv_l(0, 1, 1, 2'b00, 10, '0);       drv_r(0, 1, 1, 2'b00, 9, '0);         step();
        drain(3);

        // R9: read against a same-cycle write from the other port
        cur_req = "R9";
        drv_l(0, 1, 0, 2'b00, 9, 18'h3C3C3); drv_r(0, 1, 1, 2'b00, 9, '0); step();
        drv_l(0, 1, 1, 2'b00, 10, '0);      drv_r(0, 1, 0, 2'b10, 10, 18'h00155); step();
        drv_l(1, 1, 1, 2'b00, 0, '0);       drv_r(0, 1, 1, 2'b00, 9, '0); step();
        drv_l(0, 1, 1, 2'b00, 10, '0);      drv_r(1, 1, 1, 2'b00, 0, '0); step();
        drain(3);

        // R10: same-lane collision keeps the left data
        cur_req = "R10";
        drv_l(0, 1, 0, 2'b00, 12, 18'h00AAA); drv_r(0, 1, 0, 2'b00, 12, 18'h3F555); step();
        drv_l(0, 1, 0, 2'b10, 13, 18'h00011); drv_r(0, 1, 0, 2'b01, 13, 18'h3FE00); step();
        drv_l(0, 1, 1, 2'b00, 12, '0);        drv_r(0, 1, 1, 2'b00, 13, '0); step();
        drain(3);

        // R7: output enable gates without a clock edge
        cur_req = "R7";
        drv_l(0, 1, 1, 2'b00, 5, '0); step();
        idle_both();
        @(posedge clk);
        #(CLK_PERIOD/4);
        lt_oe_n = 1'b1;
        #1;
        n_checks++;
        if (lt_rdata_oe !== 2'b00) begin
            n_fail++;
            $display("FAIL R7 async gate: actual %b expected 00", lt_rdata_oe);
        end
        lt_oe_n = 1'b0;
        #1;
        n_checks++;
        if (lt_rdata_oe !== 2'b11) begin
            n_fail++;
            $display("FAIL R7 async release: actual %b expected 11", lt_rdata_oe);
        end
        drain(3);

        // ---- pipelined mode ----
        rst = 1'b1;
        lt_pipe = 1'b1; rt_pipe = 1'b1;
        do_reset();
        cur_req = "R5";
        drv_l(0, 1, 1, 2'b00, 5, '0); drv_r(0, 1, 1, 2'b00, 12, '0); step();
        drv_l(0, 1, 1, 2'b00, 6, '0); drv_r(0, 1, 1, 2'b00, 13, '0); step();
        drv_l(1, 1, 1, 2'b00, 0, '0); drv_r(0, 0, 1, 2'b00, 0, '0);  step();
        drain(4);
        // R6: lane selects taken one cycle after the read
        cur_req = "R6";
        drv_l(0, 1, 1, 2'b00, 9, '0);  drv_r(0, 1, 1, 2'b00, 10, '0); step();
        drv_l(1, 1, 1, 2'b01, 0, '0);  drv_r(1, 1, 1, 2'b10, 0, '0);  step();
        drv_l(1, 1, 1, 2'b11, 0, '0);  drv_r(1, 1, 1, 2'b11, 0, '0);  step();
        drain(4);
        // R1 in pipelined mode: lane write then read back
        cur_req = "R1";
        drv_l(0, 1, 0, 2'b01, 20, 18'h3FFFF); drv_r(0, 1, 0, 2'b10, 21, 18'h3FFFF); step();
        drv_l(0, 1, 1, 2'b00, 21, '0);        drv_r(0, 1, 1, 2'b00, 20, '0); step();
        drain(4);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule